// File: doc/BRIEF.md
# Preload Register Coherence Unit

This block keeps speculatively loaded register values coherent with later stores. A scheduler may hoist a load, called a preload, above stores whose addresses it cannot disambiguate. The unit holds the loaded value for the destination register. It records the load address in one of a small pool of address entries and compares every later store against all valid entries. Any store bytes that overlap the bytes the preload read are merged into the held register value. As a result, the value seen at the register's first use is the same value an in-order load would have returned.

There are fewer address entries than tracked registers. Each register carries a group field that names the entry holding its address. If a preload finds no free entry, the oldest entry is taken over and the register that owned it is frozen. A frozen register is not updated by stores. At its next use it is reloaded from its saved address, and its ready bit stays low until the reload data comes back. The first use of a register that still has an entry ends coherence for that register and frees the entry.

Top module: `preload_coherence_unit`

## Requirements
- R1: After reset, every register has its preload, freeze and trap bits at 0 and its ready bit at 1, and no reload request is raised.
- R2: A preload with a valid size and alignment does the following for its destination: it captures the data, sets the preload and ready bits, clears the freeze and trap bits, and writes the index of the lowest free address entry into the group field.
- R3: A use of a register whose preload bit is set clears that bit and frees its entry, so that a later preload gets the entry without evicting another. A use of a register with neither the preload bit nor the freeze bit set changes no status and raises no reload request.
- R4: A preload that finds no free entry takes the entry named by a round-robin pointer. The pointer starts at 0 and advances by one after each such eviction. The former owner of the entry gets freeze 1 and preload 0.
- R5: A use of a frozen register raises the reload request for one cycle, starting the cycle after the use. The request carries the register index and that register's saved address and size. The use also clears the freeze and ready bits. When the reload data returns, the unit writes that data into the register and sets the ready bit.
- R6: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. Store data is right-aligned in the store data input. When a store falls in the same 4-byte word as an entry, each register byte k below the preload size whose memory byte (preload offset + k) lies inside the store takes store data byte (preload offset + k − store offset). A store in another word, or to the address of a frozen register, changes nothing.
- R7: When a store and a use of the same tracked register arrive in the same cycle, the store data is merged first and then coherence ends.
- R8: A preload with size code 3, or with an address that is not a multiple of its size, sets the trap bit, captures the data and takes no entry.
- R9: A preload to a register that already holds an entry reuses that entry, leaves the group field unchanged and evicts nothing.
- R10: Each register's type field reads {size code[1:0], address[1:0]} of its last preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pl_valid_i | input | 1 | Preload issued |
| pl_rd_i | input | 3 | Preload destination register |
| pl_addr_i | input | 16 | Preload byte address |
| pl_size_i | input | 2 | Preload size code |
| pl_data_i | input | 32 | Loaded value |
| st_valid_i | input | 1 | Store issued |
| st_addr_i | input | 16 | Store byte address |
| st_size_i | input | 2 | Store size code |
| st_data_i | input | 32 | Store data, right-aligned |
| use_valid_i | input | 1 | Register use issued |
| use_rd_i | input | 3 | Register being used |
| rl_valid_i | input | 1 | Reload data returning |
| rl_rd_i | input | 3 | Register of returning reload |
| rl_data_i | input | 32 | Reload data |
| rl_req_o | output | 1 | Reload request pulse |
| rl_req_rd_o | output | 3 | Register to reload |
| rl_req_addr_o | output | 16 | Saved address for reload |
| rl_req_size_o | output | 2 | Saved size for reload |
| pre_o | output | 8 | Preload bit per register |
| frz_o | output | 8 | Freeze bit per register |
| rdy_o | output | 8 | Ready bit per register |
| trap_o | output | 8 | Trap bit per register |
| ptype_o | output | 32 | Type field per register, 4 bits each |
| grp_o | output | 8 | Group field per register, 1 bit each |
| data_o | output | 32x8 = 256 | Held value per register |

## Verification
The bench sweeps every legal pair of preload size and offset against every legal pair of store size and offset in the same word. A byte-lane merge with the wrong sign or a missing size limit would corrupt bytes outside the overlap or leave overlapping bytes stale. It fills both entries and then forces two evictions. If the round-robin pointer failed to advance, or the old owner were not frozen, the same entry would be evicted twice or a register would keep stale data silently. Further cases cover a use that frees an entry for a later preload, a re-preload that must not evict its neighbour, a store arriving in the same cycle as a use, which catches a design that clears coherence first and drops the store, and misaligned preloads, which must trap and take no entry.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  function automatic int size_bytes(input logic [1:0] sz);
    return 1 << int'(sz);
  endfunction
endpackage

// File: rtl/plc_cmp.sv
module plc_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              ent_v_i,
  input  logic [ADDR_W-1:0] ent_addr_i,
  input  logic [1:0]        ent_size_i,
  input  logic              st_v_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0] data_o
);
  import plc_pkg::*;
  localparam int NB   = DATA_W / 8;
  localparam int OFFW = $clog2(NB);

  logic same_word;
  int   p_off, s_off, p_n, s_n;

  always_comb begin
    same_word = ent_v_i && st_v_i &&
                (ent_addr_i[ADDR_W-1:OFFW] == st_addr_i[ADDR_W-1:OFFW]);
    p_off  = int'(ent_addr_i[OFFW-1:0]);
    s_off  = int'(st_addr_i[OFFW-1:0]);
    p_n    = size_bytes(ent_size_i);
    s_n    = size_bytes(st_size_i);
    be_o   = '0;
    data_o = '0;
    // register byte k mirrors memory byte p_off+k
    for (int k = 0; k < NB; k++) begin
      if (same_word && k < p_n && (p_off + k) < NB &&
          (p_off + k) >= s_off && (p_off + k) < (s_off + s_n)) begin
        be_o[k]          = 1'b1;
        data_o[k*8 +: 8] = st_data_i[(p_off + k - s_off)*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/plc_alloc.sv
module plc_alloc #(
  parameter int NUM_ENT = 2,
  localparam int AIW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENT-1:0] ent_v_i,
  input  logic               adv_i,
  output logic               free_o,
  output logic [AIW-1:0]     free_idx_o,
  output logic [AIW-1:0]     victim_o
);
  logic [AIW-1:0] rr_q;

  always_comb begin
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (!ent_v_i[e]) begin
        free_o     = 1'b1;
        free_idx_o = AIW'(e);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rr_q <= '0;
    else if (adv_i) rr_q <= (rr_q == AIW'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  assign victim_o = rr_q;

  AST_EVICT_ONLY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni) adv_i |-> (&ent_v_i)); // R4
endmodule

// File: rtl/preload_coherence_unit.sv
module preload_coherence_unit #(
  parameter int NUM_REGS = 8,
  parameter int NUM_ENT  = 2,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  localparam int RW   = $clog2(NUM_REGS),
  localparam int AIW  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int OFFW = $clog2(DATA_W / 8),
  localparam int PTW  = 2 + OFFW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pl_valid_i,
  input  logic [RW-1:0]              pl_rd_i,
  input  logic [ADDR_W-1:0]          pl_addr_i,
  input  logic [1:0]                 pl_size_i,
  input  logic [DATA_W-1:0]          pl_data_i,
  input  logic                       st_valid_i,
  input  logic [ADDR_W-1:0]          st_addr_i,
  input  logic [1:0]                 st_size_i,
  input  logic [DATA_W-1:0]          st_data_i,
  input  logic                       use_valid_i,
  input  logic [RW-1:0]              use_rd_i,
  input  logic                       rl_valid_i,
  input  logic [RW-1:0]              rl_rd_i,
  input  logic [DATA_W-1:0]          rl_data_i,
  output logic                       rl_req_o,
  output logic [RW-1:0]              rl_req_rd_o,
  output logic [ADDR_W-1:0]          rl_req_addr_o,
  output logic [1:0]                 rl_req_size_o,
  output logic [NUM_REGS-1:0]        pre_o,
  output logic [NUM_REGS-1:0]        frz_o,
  output logic [NUM_REGS-1:0]        rdy_o,
  output logic [NUM_REGS-1:0]        trap_o,
  output logic [NUM_REGS*PTW-1:0]    ptype_o,
  output logic [NUM_REGS*AIW-1:0]    grp_o,
  output logic [NUM_REGS*DATA_W-1:0] data_o
);
  import plc_pkg::*;
  localparam int NB = DATA_W / 8;

  // per-register state
  logic [NUM_REGS-1:0] pre_q, frz_q, rdy_q, trap_q;
  logic [1:0]          sz_q   [NUM_REGS];
  logic [ADDR_W-1:0]   addr_q [NUM_REGS];
  logic [AIW-1:0]      grp_q  [NUM_REGS];
  logic [DATA_W-1:0]   data_q [NUM_REGS];
  logic [DATA_W-1:0]   st_nx  [NUM_REGS];

  // address entries
  logic [NUM_ENT-1:0]  ev_q;
  logic [ADDR_W-1:0]   ea_q [NUM_ENT];
  logic [1:0]          es_q [NUM_ENT];
  logic [RW-1:0]       eo_q [NUM_ENT];
  logic [NB-1:0]       cbe  [NUM_ENT];
  logic [DATA_W-1:0]   cdat [NUM_ENT];

  logic              rl_req_q;
  logic [RW-1:0]     rl_rd_q;
  logic [ADDR_W-1:0] rl_addr_q;
  logic [1:0]        rl_size_q;

  logic           free, pl_bad, pl_own, evict, spare_victim;
  logic [AIW-1:0] free_idx, victim, slot;
  logic [RW-1:0]  vic_owner;
  int             pl_n;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    plc_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .ent_v_i   (ev_q[e]),
      .ent_addr_i(ea_q[e]),
      .ent_size_i(es_q[e]),
      .st_v_i    (st_valid_i),
      .st_addr_i (st_addr_i),
      .st_size_i (st_size_i),
      .st_data_i (st_data_i),
      .be_o      (cbe[e]),
      .data_o    (cdat[e])
    );
  end

  plc_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ent_v_i   (ev_q),
    .adv_i     (evict),
    .free_o    (free),
    .free_idx_o(free_idx),
    .victim_o  (victim)
  );

  // store merge into owner registers
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      st_nx[r] = data_q[r];
      for (int e = 0; e < NUM_ENT; e++) begin
        if (ev_q[e] && eo_q[e] == RW'(r)) begin
          for (int k = 0; k < NB; k++) begin
            if (cbe[e][k]) st_nx[r][k*8 +: 8] = cdat[e][k*8 +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    pl_n   = size_bytes(pl_size_i);
    pl_bad = (pl_n > NB) || ((int'(pl_addr_i[OFFW-1:0]) % pl_n) != 0);
    pl_own = pre_q[pl_rd_i];
    slot   = pl_own ? grp_q[pl_rd_i] : (free ? free_idx : victim);
    evict  = pl_valid_i && !pl_bad && !pl_own && !free;
    vic_owner    = eo_q[victim];
    // owner being used this cycle gives the entry up without freezing
    spare_victim = use_valid_i && (use_rd_i == vic_owner);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      frz_q  <= '0;
      rdy_q  <= '1;
      trap_q <= '0;
      ev_q   <= '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        sz_q[r]   <= '0;
        addr_q[r] <= '0;
        grp_q[r]  <= '0;
        data_q[r] <= '0;
      end
      for (int e = 0; e < NUM_ENT; e++) begin
        ea_q[e] <= '0;
        es_q[e] <= '0;
        eo_q[e] <= '0;
      end
      rl_req_q  <= 1'b0;
      rl_rd_q   <= '0;
      rl_addr_q <= '0;
      rl_size_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) data_q[r] <= st_nx[r];
      rl_req_q <= 1'b0;

      if (use_valid_i) begin
        if (pre_q[use_rd_i]) begin
          pre_q[use_rd_i]       <= 1'b0;
          ev_q[grp_q[use_rd_i]] <= 1'b0;
        end
        if (frz_q[use_rd_i]) begin
          frz_q[use_rd_i] <= 1'b0;
          rdy_q[use_rd_i] <= 1'b0;
          rl_req_q  <= 1'b1;
          rl_rd_q   <= use_rd_i;
          rl_addr_q <= addr_q[use_rd_i];
          rl_size_q <= sz_q[use_rd_i];
        end
      end

      if (pl_valid_i) begin
        data_q[pl_rd_i] <= pl_data_i;
        rdy_q[pl_rd_i]  <= 1'b1;
        frz_q[pl_rd_i]  <= 1'b0;
        trap_q[pl_rd_i] <= pl_bad;
        sz_q[pl_rd_i]   <= pl_size_i;
        addr_q[pl_rd_i] <= pl_addr_i;
        if (pl_bad) begin
          pre_q[pl_rd_i] <= 1'b0;
          if (pl_own) ev_q[grp_q[pl_rd_i]] <= 1'b0;
        end else begin
          pre_q[pl_rd_i] <= 1'b1;
          grp_q[pl_rd_i] <= slot;
          ev_q[slot]     <= 1'b1;
          ea_q[slot]     <= pl_addr_i;
          es_q[slot]     <= pl_size_i;
          eo_q[slot]     <= pl_rd_i;
          if (evict && !spare_victim) begin
            frz_q[vic_owner] <= 1'b1;
            pre_q[vic_owner] <= 1'b0;
          end
        end
      end

      if (rl_valid_i) begin
        data_q[rl_rd_i] <= rl_data_i;
        rdy_q[rl_rd_i]  <= 1'b1;
      end
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_out
    assign ptype_o[r*PTW +: PTW]       = {sz_q[r], addr_q[r][OFFW-1:0]};
    assign grp_o[r*AIW +: AIW]         = grp_q[r];
    assign data_o[r*DATA_W +: DATA_W]  = data_q[r];
    AST_GRP_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni) pre_q[r] |-> (ev_q[grp_q[r]] && eo_q[grp_q[r]] == RW'(r))); // R2
  end

  assign pre_o         = pre_q;
  assign frz_o         = frz_q;
  assign rdy_o         = rdy_q;
  assign trap_o        = trap_q;
  assign rl_req_o      = rl_req_q;
  assign rl_req_rd_o   = rl_rd_q;
  assign rl_req_addr_o = rl_addr_q;
  assign rl_req_size_o = rl_size_q;

  AST_PRE_FRZ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) (pre_q & frz_q) == '0); // R4
  AST_ENTRY_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(pre_q) == $countones(ev_q)); // R3
  AST_REQ_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni) rl_req_q |-> !rdy_q[rl_rd_q]); // R5
  AST_USE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni) (use_valid_i && pre_q[use_rd_i] && !(pl_valid_i && pl_rd_i == use_rd_i)) |=> !pre_q[$past(use_rd_i)]); // R3
endmodule

// File: tb/preload_coherence_unit_tb.sv
module preload_coherence_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pl_valid_i = 0, st_valid_i = 0, use_valid_i = 0, rl_valid_i = 0;
  logic [2:0]  pl_rd_i = 0, use_rd_i = 0, rl_rd_i = 0;
  logic [15:0] pl_addr_i = 0, st_addr_i = 0;
  logic [1:0]  pl_size_i = 0, st_size_i = 0;
  logic [31:0] pl_data_i = 0, st_data_i = 0, rl_data_i = 0;
  logic        rl_req_o;
  logic [2:0]  rl_req_rd_o;
  logic [15:0] rl_req_addr_o;
  logic [1:0]  rl_req_size_o;
  logic [7:0]  pre_o, frz_o, rdy_o, trap_o, grp_o;
  logic [31:0] ptype_o;
  logic [255:0] data_o;

  int nchk = 0;
  int nfail = 0;

  always #10 clk_i = ~clk_i;

  preload_coherence_unit u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdat(input int r);
    return data_o[r*32 +: 32];
  endfunction

  task automatic do_pl(input logic [2:0] rd, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    pl_valid_i = 1; pl_rd_i = rd; pl_addr_i = a; pl_size_i = sz; pl_data_i = d;
    @(negedge clk_i);
    pl_valid_i = 0;
  endtask

  task automatic do_st(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    st_valid_i = 1; st_addr_i = a; st_size_i = sz; st_data_i = d;
    @(negedge clk_i);
    st_valid_i = 0;
  endtask

  task automatic do_use(input logic [2:0] rd);
    use_valid_i = 1; use_rd_i = rd;
    @(negedge clk_i);
    use_valid_i = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] sd;
    int vec;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 pre",  {24'd0, pre_o},  32'd0);
    chk("R1 frz",  {24'd0, frz_o},  32'd0);
    chk("R1 rdy",  {24'd0, rdy_o},  32'hFF);
    chk("R1 trap", {24'd0, trap_o}, 32'd0);
    chk("R1 req",  {31'd0, rl_req_o}, 32'd0);

    // R6 sweep of byte overlap in one word
    vec = 0;
    for (int psz = 0; psz < 3; psz++) begin
      for (int po = 0; po < 4; po += (1 << psz)) begin
        for (int ssz = 0; ssz < 3; ssz++) begin
          for (int so = 0; so < 4; so += (1 << ssz)) begin
            sd = 32'h11223344 + vec * 32'h01010101;
            do_pl(3'd1, 16'h0100 + 16'(po), 2'(psz), 32'hA1B2C3D4);
            do_st(16'h0100 + 16'(so), 2'(ssz), sd);
            exp = 32'hA1B2C3D4;
            for (int k = 0; k < 4; k++) begin
              if (k < (1 << psz) && po + k >= so && po + k < so + (1 << ssz))
                exp[k*8 +: 8] = sd[(po + k - so)*8 +: 8];
            end
            chk("R6 merge", rdat(1), exp);
            do_use(3'd1);
            vec++;
          end
        end
      end
    end

    // R6 store in another word
    do_pl(3'd1, 16'h0100, 2'd2, 32'h0BADF00D);
    do_st(16'h0104, 2'd2, 32'hFFFFFFFF);
    chk("R6 other word", rdat(1), 32'h0BADF00D);
    do_use(3'd1);
    chk("R3 release", {31'd0, pre_o[1]}, 32'd0);

    // R2 allocation, R10 type field
    do_pl(3'd2, 16'h0200, 2'd2, 32'hD2D2D2D2);
    do_pl(3'd3, 16'h0300, 2'd2, 32'hD3D3D3D3);
    chk("R2 grp2", {31'd0, grp_o[2]}, 32'd0);
    chk("R2 grp3", {31'd0, grp_o[3]}, 32'd1);
    chk("R2 pre",  {24'd0, pre_o}, 32'h0C);
    chk("R2 data", rdat(2), 32'hD2D2D2D2);
    chk("R10 type3", {28'd0, ptype_o[12 +: 4]}, 32'h8);

    // R4 evictions in round-robin order
    do_pl(3'd4, 16'h0402, 2'd1, 32'h0000D4D4);
    chk("R4 frz2", {31'd0, frz_o[2]}, 32'd1);
    chk("R4 pre2", {31'd0, pre_o[2]}, 32'd0);
    chk("R4 grp4", {31'd0, grp_o[4]}, 32'd0);
    chk("R10 type4", {28'd0, ptype_o[16 +: 4]}, 32'h6);
    do_pl(3'd5, 16'h0500, 2'd0, 32'h000000D5);
    chk("R4 frz3", {31'd0, frz_o[3]}, 32'd1);
    chk("R4 grp5", {31'd0, grp_o[5]}, 32'd1);

    // R6 frozen register no longer tracked
    do_st(16'h0200, 2'd2, 32'h12345678);
    chk("R6 frozen", rdat(2), 32'hD2D2D2D2);

    // R5 reload of frozen register
    do_use(3'd2);
    chk("R5 req",  {31'd0, rl_req_o}, 32'd1);
    chk("R5 rd",   {29'd0, rl_req_rd_o}, 32'd2);
    chk("R5 addr", {16'd0, rl_req_addr_o}, 32'h0200);
    chk("R5 size", {30'd0, rl_req_size_o}, 32'd2);
    chk("R5 rdy",  {31'd0, rdy_o[2]}, 32'd0);
    chk("R5 frz",  {31'd0, frz_o[2]}, 32'd0);
    @(negedge clk_i);
    chk("R5 pulse", {31'd0, rl_req_o}, 32'd0);
    rl_valid_i = 1; rl_rd_i = 3'd2; rl_data_i = 32'h12345678;
    @(negedge clk_i);
    rl_valid_i = 0;
    chk("R5 rdy back", {31'd0, rdy_o[2]}, 32'd1);
    chk("R5 data", rdat(2), 32'h12345678);

    // R3 use frees entry, no eviction follows
    do_use(3'd4);
    chk("R3 pre4", {31'd0, pre_o[4]}, 32'd0);
    do_pl(3'd6, 16'h0600, 2'd2, 32'hD6D6D6D6);
    chk("R3 grp6", {31'd0, grp_o[6]}, 32'd0);
    chk("R3 no evict", {30'd0, pre_o[5], frz_o[5]}, 32'h2);

    // R3 use of untracked register
    do_use(3'd0);
    chk("R3 idle use", {16'd0, pre_o, frz_o}, 32'h6008);
    chk("R3 idle req", {31'd0, rl_req_o}, 32'd0);

    // R9 re-preload reuses entry
    do_pl(3'd5, 16'h0700, 2'd2, 32'h00000000);
    chk("R9 grp5", {31'd0, grp_o[5]}, 32'd1);
    chk("R9 keep6", {30'd0, pre_o[6], frz_o[6]}, 32'h2);
    do_st(16'h0700, 2'd2, 32'hCAFEBABE);
    chk("R9 new addr", rdat(5), 32'hCAFEBABE);

    // R7 store and use in one cycle
    st_valid_i = 1; st_addr_i = 16'h0600; st_size_i = 2'd2; st_data_i = 32'h5A5A0F0F;
    use_valid_i = 1; use_rd_i = 3'd6;
    @(negedge clk_i);
    st_valid_i = 0; use_valid_i = 0;
    chk("R7 data", rdat(6), 32'h5A5A0F0F);
    chk("R7 pre", {31'd0, pre_o[6]}, 32'd0);

    // R8 traps
    do_pl(3'd7, 16'h0801, 2'd1, 32'h00007777);
    chk("R8 trap", {31'd0, trap_o[7]}, 32'd1);
    chk("R8 no entry", {31'd0, pre_o[7]}, 32'd0);
    chk("R8 data", rdat(7), 32'h00007777);
    do_pl(3'd7, 16'h0800, 2'd3, 32'h0);
    chk("R8 size3", {31'd0, trap_o[7]}, 32'd1);
    do_pl(3'd7, 16'h0803, 2'd0, 32'h00000077);
    chk("R8 clear", {30'd0, trap_o[7], pre_o[7]}, 32'h1);

    finish_run();
  end
endmodule